// File: doc/BRIEF.md
# Serial-in shift register with output latch

This block takes serial data in one bit at a time and presents it as a parallel word. It holds two registers of equal width. A shift chain advances on each rising edge of a shift clock. A storage register takes a snapshot of the whole chain on each rising edge of a separate latch clock. The parallel outputs show the storage register. An active-low enable either drives them or releases them to high impedance. A cascade output always carries the last stage of the chain, so several blocks can be chained into a longer shift register.

An asynchronous active-low reset empties the shift chain at once. It leaves the storage register alone, so the parallel outputs keep showing the last latched word while the chain is cleared. Both clocks are edge-triggered inputs with no assumed relation between them. When both rise at the same moment, the storage register takes the chain contents from before that shift.

An internal output mode, drive or release, is chosen from the enable level. The transitions are: DRIVE to RELEASE when the enable goes high, and RELEASE to DRIVE when it goes low.

Top module: `sipo_latch_reg`

## Requirements
- R1: On each rising edge of `sh_clk`, `ser_in` enters stage 0 and every stage k moves into stage k+1. The word in the last stage is dropped.
- R2: While `rst_n` is low, every shift stage is zero at once, without waiting for a clock edge, and `ser_out` reads 0.
- R3: Reset does not change the storage register. The parallel outputs keep the last latched word through reset.
- R4: On each rising edge of `lt_clk`, storage bit k takes the value of shift stage k.
- R5: Without a rising edge on `lt_clk`, the storage register holds its value, even while `sh_clk` keeps shifting.
- R6: With `oe_n` low, `par_q[k]` drives storage bit k without inversion. Bit 0 is the stage that the most recent serial bit entered.
- R7: With `oe_n` high, all bits of `par_q` are high impedance. A bus with a pull-up then reads all ones.
- R8: `ser_out` always equals the last shift stage and is driven whatever the level of `oe_n`.
- R9: When `sh_clk` and `lt_clk` rise together, the storage register captures the chain as it was before that shift.
- R10: With two blocks chained (`ser_out` of the first into `ser_in` of the second, shift clocks shared), the first bit shifted in appears on the second block's `ser_out` after 16 shift edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sh_clk | input | 1 | Shift clock, acts on rising edge |
| lt_clk | input | 1 | Latch clock, acts on rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of the shift chain |
| oe_n | input | 1 | Active-low enable of the parallel outputs |
| ser_in | input | 1 | Serial data input |
| par_q | output | WIDTH | Tri-state parallel outputs from the storage register |
| ser_out | output | 1 | Cascade output, last shift stage |

## Verification
The bench builds two blocks with the default WIDTH of 8 and chains them, so that one 16-bit reference queue predicts both the cascade path and the boundary between the two blocks. The eight-stage depth keeps full shift-and-latch sequences short. Within a few hundred clocks this covers directed cases for reset during held data, simultaneous edges and tri-state release, followed by a random run. The parallel bus of the first block has a pull-up, so a released output reads differently from a driven word that contains zeros.

// File: rtl/sipo_latch_pkg.sv
package sipo_latch_pkg;

    typedef enum logic {
        OUT_DRIVE   = 1'b0,
        OUT_RELEASE = 1'b1
    } out_mode_t;

endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
    parameter int WIDTH = 8
) (
    input  logic             sh_clk,
    input  logic             rst_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stage_q
);

    // one flop per stage; stage 0 takes the serial input
    for (genvar k = 0; k < WIDTH; k++) begin : g_stage
        logic next_bit;
        if (k == 0) begin : g_head
            assign next_bit = ser_in;
        end else begin : g_body
            assign next_bit = stage_q[k-1];
        end

        always_ff @(posedge sh_clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[k] <= 1'b0;
            end else begin
                stage_q[k] <= next_bit;
            end
        end
    end

endmodule

// File: rtl/sipo_store_reg.sv
module sipo_store_reg #(
    parameter int WIDTH = 8
) (
    input  logic             lt_clk,
    input  logic [WIDTH-1:0] snap_d,
    output logic [WIDTH-1:0] store_q
);

    // no reset on purpose: the snapshot survives a chain clear
    always_ff @(posedge lt_clk) begin
        store_q <= snap_d;
    end

endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg
    import sipo_latch_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             sh_clk,
    input  logic             lt_clk,
    input  logic             rst_n,
    input  logic             oe_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] par_q,
    output logic             ser_out
);

    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] store_q;
    out_mode_t        out_mode;

    sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .sh_clk  (sh_clk),
        .rst_n   (rst_n),
        .ser_in  (ser_in),
        .stage_q (stage_q)
    );

    sipo_store_reg #(.WIDTH(WIDTH)) u_store (
        .lt_clk  (lt_clk),
        .snap_d  (stage_q),
        .store_q (store_q)
    );

    // output mode follows the enable level directly
    always_comb begin
        unique case (oe_n)
            1'b0:    out_mode = OUT_DRIVE;
            default: out_mode = OUT_RELEASE;
        endcase
    end

    assign par_q   = (out_mode == OUT_DRIVE) ? store_q : {WIDTH{1'bz}};
    assign ser_out = stage_q[LAST];

endmodule

// File: rtl/sipo_latch_reg_chk.sv
module sipo_latch_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             sh_clk,
    input logic             lt_clk,
    input logic             rst_n,
    input logic             ser_in,
    input logic             ser_out,
    input logic [WIDTH-1:0] stage_q,
    input logic [WIDTH-1:0] store_q
);

    logic [WIDTH-1:0] exp_chain;
    logic [WIDTH-1:0] snap_at_latch;
    logic             latched_once = 1'b0;

    always_ff @(posedge sh_clk or negedge rst_n) begin
        if (!rst_n) exp_chain <= '0;
        else        exp_chain <= {exp_chain[WIDTH-2:0], ser_in};
    end

    always_ff @(posedge lt_clk) begin
        snap_at_latch <= stage_q;
        latched_once  <= 1'b1;
    end

    AST_CHAIN_ADVANCE: assert property (@(posedge lt_clk) disable iff (!rst_n)
        stage_q == exp_chain);                                   // R1

    AST_RESET_EMPTIES: assert property (@(posedge lt_clk)
        !rst_n |-> (stage_q == '0 && ser_out == 1'b0));          // R2

    AST_STORE_SNAPSHOT: assert property (@(posedge sh_clk) disable iff (!latched_once)
        store_q == snap_at_latch);                               // R4

    AST_CASCADE_TAP: assert property (@(posedge lt_clk) disable iff (!rst_n)
        ser_out == exp_chain[WIDTH-1]);                          // R8

endmodule

bind sipo_latch_reg sipo_latch_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .sh_clk  (sh_clk),
    .lt_clk  (lt_clk),
    .rst_n   (rst_n),
    .ser_in  (ser_in),
    .ser_out (ser_out),
    .stage_q (stage_q),
    .store_q (store_q)
);

// File: tb/sipo_latch_reg_bench.sv
module sipo_latch_reg_bench;

    localparam int W = 8;

    logic clk    = 1'b0;
    logic sh_clk = 1'b0;
    logic lt_clk = 1'b0;
    logic rst_n  = 1'b0;
    logic oe_n   = 1'b1;
    logic din    = 1'b0;

    wire  [W-1:0] q_a;
    wire  [W-1:0] q_b;
    logic         so_a;
    logic         so_b;

    int checks = 0;
    int fails  = 0;

    // reference: 16-bit chain, device A = low byte, device B = high byte
    logic [2*W-1:0] ref_chain = '0;
    logic [W-1:0]   ref_store_a = '0;
    logic [W-1:0]   ref_store_b = '0;
    bit             ref_latched = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    for (genvar i = 0; i < W; i++) begin : g_pu
        pullup (q_a[i]);
    end

    sipo_latch_reg #(.WIDTH(W)) u_sipo_latch_reg (
        .sh_clk (sh_clk), .lt_clk (lt_clk), .rst_n (rst_n), .oe_n (oe_n),
        .ser_in (din), .par_q (q_a), .ser_out (so_a)
    );

    sipo_latch_reg #(.WIDTH(W)) u_sipo_latch_reg_tail (
        .sh_clk (sh_clk), .lt_clk (lt_clk), .rst_n (rst_n), .oe_n (1'b0),
        .ser_in (so_a), .par_q (q_b), .ser_out (so_b)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R8 ser_out A", {7'b0, so_a}, {7'b0, ref_chain[W-1]});
        check("R10 ser_out B", {7'b0, so_b}, {7'b0, ref_chain[2*W-1]});
        if (ref_latched) begin
            check(oe_n ? "R7 released" : "R6 driven", q_a, oe_n ? '1 : ref_store_a);
            check("R6 tail driven", q_b, ref_store_b);
        end
    endtask

    // one 8 ns step: optional shift edge, optional latch edge
    task automatic step(input bit do_sh, input bit do_lt, input bit d, input bit oe);
        @(posedge clk);
        din  = d;
        oe_n = oe;
        #2;
        if (do_lt) begin
            ref_store_a = ref_chain[W-1:0];
            ref_store_b = ref_chain[2*W-1:W];
            ref_latched = 1'b1;
        end
        if (do_sh) ref_chain = {ref_chain[2*W-2:0], d};
        sh_clk = do_sh;
        lt_clk = do_lt;
        #3;
        sh_clk = 1'b0;
        lt_clk = 1'b0;
        #1;
        compare_all();
    endtask

    task automatic shift_byte(input logic [W-1:0] b);
        for (int i = W - 1; i >= 0; i--) step(1, 0, b[i], oe_n);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        #10;
        check("R2 reset so A", {7'b0, so_a}, 8'h00);
        check("R2 reset so B", {7'b0, so_b}, 8'h00);
        rst_n = 1'b1;

        // R1 / R8: shift a pattern, serial output tracks the last stage
        shift_byte(8'hA5);
        // R4 / R6: latch, then drive
        step(0, 1, 0, 0);
        check("R4 latch A5", q_a, 8'hA5);

        // R6: only stage 0 set -> bit 0
        shift_byte(8'h01);
        step(0, 1, 0, 0);
        check("R6 bit0 is stage0", q_a, 8'h01);

        // R5: shifting without latching leaves outputs alone
        shift_byte(8'h3C);
        check("R5 hold while shifting", q_a, 8'h01);

        // R7 / R8: release the bus, serial still driven
        step(0, 0, 0, 1);
        check("R7 released reads pull-up", q_a, 8'hFF);
        check("R8 so with oe high", {7'b0, so_a}, {7'b0, ref_chain[W-1]});
        step(1, 0, 1, 1);
        step(0, 0, 0, 0);
        check("R7 re-enabled", q_a, 8'h01);

        // R9: simultaneous edges capture pre-shift chain
        shift_byte(8'h5A);
        step(1, 1, 1, 0);
        check("R9 pre-shift capture", q_a, 8'h5A);

        // R2 / R3: asynchronous clear between edges
        @(posedge clk); #1;
        rst_n = 1'b0;
        #1;
        ref_chain = '0;
        check("R2 clear immediate", {7'b0, so_a}, 8'h00);
        check("R3 store kept", q_a, 8'h5A);
        #3;
        rst_n = 1'b1;
        step(0, 1, 0, 0);
        check("R2 chain empty after clear", q_a, 8'h00);

        // R10: one marked bit travels 16 stages
        step(1, 0, 1, 0);
        for (int i = 0; i < 2 * W - 2; i++) step(1, 0, 0, 0);
        check("R10 before 16th edge", {7'b0, so_b}, 8'h00);
        step(1, 0, 0, 0);
        check("R10 after 16th edge", {7'b0, so_b}, 8'h01);

        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            step(r[0], r[1], r[2], r[3]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule